// File: doc/BRIEF.md
# Register Status and Rename Table

This block keeps, for every architectural register, a status bit that says whether the register file holds the current value, plus the register file storage itself. While a register is pending, the table holds the tag of the reorder-buffer slot that will produce it, not data. The issue logic presents two source register numbers and gets back, for each one, a ready flag, the producer tag and the committed register value. When the ready flag is low, the consumer fetches the operand from the tagged reorder-buffer slot.

At decode, an allocate request marks the destination register pending and stores the new slot tag. A later writer of the same register simply replaces the tag. This renaming removes write-after-write and write-after-read hazards. When an instruction retires in program order, the commit port writes its result into the register file. The register becomes ready again only if it still maps to the retiring slot, so a younger writer's mapping survives. A flush makes every register ready again, because after a flush the committed register file holds the precise state. Register 0 can optionally be hardwired as always ready, reading zero and never renamed.

Top module: `reg_rename_table`

## Requirements
- R1: After reset every register reads ready, with tag 0 and value 0.
- R2: An allocate of register r with tag t (no flush in that cycle) makes r read not ready with tag t from the next cycle on.
- R3: Both source ports return the ready flag, tag and value of their own register independently. A later allocate of the same register replaces the earlier tag.
- R4: A commit with tag t makes a pending register r ready again from the next cycle only if r's stored tag equals t and r is not allocated in that cycle. If the tags differ, r stays pending with its tag unchanged.
- R5: A commit of register r always writes its data into r's register file entry, visible on the source ports from the next cycle.
- R6: A flush makes every register ready from the next cycle and discards an allocate in the same cycle. Tags are kept, and a same-cycle commit still writes its data.
- R7: Source outputs reflect the state before the current cycle's allocate, commit or flush (no same-cycle bypass).
- R8: With ZERO_FIXED=1, register 0 always reads ready with tag 0 and value 0. Allocates and commits naming it are ignored.
- R9: When an allocate and a commit name the same register in the same cycle, the allocate decides the status: the register ends pending with the new tag, and the commit data is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Return all registers to ready |
| srcAReg | input | REG_W | First source register number |
| srcBReg | input | REG_W | Second source register number |
| srcAValid | output | 1 | First source is in the register file |
| srcATag | output | TAG_W | Producer tag of first source |
| srcAData | output | DATA_W | Register file value of first source |
| srcBValid | output | 1 | Second source is in the register file |
| srcBTag | output | TAG_W | Producer tag of second source |
| srcBData | output | DATA_W | Register file value of second source |
| allocEn | input | 1 | Destination allocate request |
| allocReg | input | REG_W | Destination register being renamed |
| allocTag | input | TAG_W | Reorder-buffer slot of the new writer |
| commitEn | input | 1 | In-order retirement strobe |
| commitReg | input | REG_W | Register written by the retiring instruction |
| commitTag | input | TAG_W | Slot of the retiring instruction |
| commitData | input | DATA_W | Result to store in the register file |

## Verification
The properties assume that NUM_REGS is a power of two, so every register number on a port names a real entry. They also assume that commit tags are arbitrary values rather than tags known to match, so the mismatch property must hold for any commit the bench offers. Stimulus keeps register numbers within the lowest eight entries so that allocates, commits and lookups collide often. In most cycles, the commit tag is taken from the tag the reference model currently holds for that register, which exercises both the revalidate and the keep-pending outcomes.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic doFlush;
    logic doAlloc;
    logic doCommit;
  } rrt_strobe_t;

endpackage

// File: rtl/rrt_ctrl.sv
module rrt_ctrl
  import rrt_pkg::*;
#(
  parameter int NUM_REGS   = 32,
  parameter int ZERO_FIXED = 1,
  localparam int REG_W     = $clog2(NUM_REGS)
) (
  input  logic                flush,
  input  logic                allocEn,
  input  logic [REG_W-1:0]    allocReg,
  input  logic                commitEn,
  input  logic [REG_W-1:0]    commitReg,
  output rrt_strobe_t         strobe,
  output logic [NUM_REGS-1:0] allocHot,
  output logic [NUM_REGS-1:0] commitHot
);

  logic allocZero;
  logic commitZero;

  // register 0 is excluded from renaming and writes when fixed
  assign allocZero  = (ZERO_FIXED != 0) && (allocReg == '0);
  assign commitZero = (ZERO_FIXED != 0) && (commitReg == '0);

  always_comb begin
    strobe.doFlush  = flush;
    strobe.doAlloc  = allocEn && !flush && !allocZero;
    strobe.doCommit = commitEn && !commitZero;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_decode
    assign allocHot[r]  = strobe.doAlloc  && (allocReg  == REG_W'(r));
    assign commitHot[r] = strobe.doCommit && (commitReg == REG_W'(r));
  end

endmodule

// File: rtl/rrt_datapath.sv
module rrt_datapath
  import rrt_pkg::*;
#(
  parameter int NUM_REGS   = 32,
  parameter int TAG_W      = 6,
  parameter int DATA_W     = 32,
  parameter int ZERO_FIXED = 1,
  parameter int NUM_SRC    = 2,
  localparam int REG_W     = $clog2(NUM_REGS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  rrt_strobe_t                       strobe,
  input  logic [NUM_REGS-1:0]               allocHot,
  input  logic [NUM_REGS-1:0]               commitHot,
  input  logic [TAG_W-1:0]                  allocTag,
  input  logic [TAG_W-1:0]                  commitTag,
  input  logic [DATA_W-1:0]                 commitData,
  input  logic [NUM_SRC-1:0][REG_W-1:0]     srcReg,
  output logic [NUM_SRC-1:0]                srcValid,
  output logic [NUM_SRC-1:0][TAG_W-1:0]     srcTag,
  output logic [NUM_SRC-1:0][DATA_W-1:0]    srcData,
  output logic [NUM_REGS-1:0]               validVec,
  output logic [NUM_REGS-1:0][TAG_W-1:0]    tagVec
);

  logic [NUM_REGS-1:0][DATA_W-1:0] dataVec;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_entry
    if ((ZERO_FIXED != 0) && (r == 0)) begin : g_fixed
      assign validVec[r] = 1'b1;
      assign tagVec[r]   = '0;
      assign dataVec[r]  = '0;
    end else begin : g_live
      logic              validQ;
      logic [TAG_W-1:0]  tagQ;
      logic [DATA_W-1:0] dataQ;
      logic              retireHit;

      // the retiring slot is still the newest writer of this register
      assign retireHit = commitHot[r] && !validQ && (tagQ == commitTag);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          validQ <= 1'b1;
          tagQ   <= '0;
          dataQ  <= '0;
        end else begin
          if (commitHot[r]) begin
            dataQ <= commitData;
          end
          if (strobe.doFlush) begin
            validQ <= 1'b1;
          end else if (allocHot[r]) begin
            validQ <= 1'b0;
            tagQ   <= allocTag;
          end else if (retireHit) begin
            validQ <= 1'b1;
          end
        end
      end

      assign validVec[r] = validQ;
      assign tagVec[r]   = tagQ;
      assign dataVec[r]  = dataQ;
    end
  end

  // lookups read pre-update state: no bypass of this cycle's writes
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_lookup
    assign srcValid[s] = validVec[srcReg[s]];
    assign srcTag[s]   = tagVec[srcReg[s]];
    assign srcData[s]  = dataVec[srcReg[s]];
  end

endmodule

// File: rtl/reg_rename_table.sv
module reg_rename_table
  import rrt_pkg::*;
#(
  parameter int NUM_REGS   = 32,
  parameter int TAG_W      = 6,
  parameter int DATA_W     = 32,
  parameter int ZERO_FIXED = 1,
  localparam int REG_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [REG_W-1:0]  srcAReg,
  input  logic [REG_W-1:0]  srcBReg,
  output logic              srcAValid,
  output logic [TAG_W-1:0]  srcATag,
  output logic [DATA_W-1:0] srcAData,
  output logic              srcBValid,
  output logic [TAG_W-1:0]  srcBTag,
  output logic [DATA_W-1:0] srcBData,
  input  logic              allocEn,
  input  logic [REG_W-1:0]  allocReg,
  input  logic [TAG_W-1:0]  allocTag,
  input  logic              commitEn,
  input  logic [REG_W-1:0]  commitReg,
  input  logic [TAG_W-1:0]  commitTag,
  input  logic [DATA_W-1:0] commitData
);

  localparam int NUM_SRC = 2;

  rrt_strobe_t                       strobe;
  logic [NUM_REGS-1:0]               allocHot;
  logic [NUM_REGS-1:0]               commitHot;
  logic [NUM_SRC-1:0][REG_W-1:0]     srcReg;
  logic [NUM_SRC-1:0]                srcValid;
  logic [NUM_SRC-1:0][TAG_W-1:0]     srcTag;
  logic [NUM_SRC-1:0][DATA_W-1:0]    srcData;
  logic [NUM_REGS-1:0]               validVec;
  logic [NUM_REGS-1:0][TAG_W-1:0]    tagVec;

  assign srcReg[0] = srcAReg;
  assign srcReg[1] = srcBReg;

  rrt_ctrl #(
    .NUM_REGS  (NUM_REGS),
    .ZERO_FIXED(ZERO_FIXED)
  ) ctrl_i (
    .flush    (flush),
    .allocEn  (allocEn),
    .allocReg (allocReg),
    .commitEn (commitEn),
    .commitReg(commitReg),
    .strobe   (strobe),
    .allocHot (allocHot),
    .commitHot(commitHot)
  );

  rrt_datapath #(
    .NUM_REGS  (NUM_REGS),
    .TAG_W     (TAG_W),
    .DATA_W    (DATA_W),
    .ZERO_FIXED(ZERO_FIXED),
    .NUM_SRC   (NUM_SRC)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .allocHot  (allocHot),
    .commitHot (commitHot),
    .allocTag  (allocTag),
    .commitTag (commitTag),
    .commitData(commitData),
    .srcReg    (srcReg),
    .srcValid  (srcValid),
    .srcTag    (srcTag),
    .srcData   (srcData),
    .validVec  (validVec),
    .tagVec    (tagVec)
  );

  assign srcAValid = srcValid[0];
  assign srcATag   = srcTag[0];
  assign srcAData  = srcData[0];
  assign srcBValid = srcValid[1];
  assign srcBTag   = srcTag[1];
  assign srcBData  = srcData[1];

endmodule

// File: rtl/reg_rename_table_chk.sv
module reg_rename_table_chk #(
  parameter int NUM_REGS   = 32,
  parameter int TAG_W      = 6,
  parameter int DATA_W     = 32,
  parameter int ZERO_FIXED = 1,
  localparam int REG_W     = $clog2(NUM_REGS)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           flush,
  input logic [REG_W-1:0]               srcAReg,
  input logic                           srcAValid,
  input logic [TAG_W-1:0]               srcATag,
  input logic [DATA_W-1:0]              srcAData,
  input logic                           srcBValid,
  input logic                           allocEn,
  input logic [REG_W-1:0]               allocReg,
  input logic [TAG_W-1:0]               allocTag,
  input logic                           commitEn,
  input logic [REG_W-1:0]               commitReg,
  input logic [TAG_W-1:0]               commitTag,
  input logic [DATA_W-1:0]              commitData,
  input logic [NUM_REGS-1:0]            validVec,
  input logic [NUM_REGS-1:0][TAG_W-1:0] tagVec
);

  logic allocLive;
  logic commitLive;
  logic sameReg;

  assign allocLive  = allocEn && !flush && !((ZERO_FIXED != 0) && (allocReg == '0));
  assign commitLive = commitEn && !((ZERO_FIXED != 0) && (commitReg == '0));
  assign sameReg    = allocLive && (allocReg == commitReg);

  // R2: an allocated register reads pending with the new tag next cycle
  p_alloc_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (allocLive ##1 (srcAReg == $past(allocReg)))
      |-> (!srcAValid && (srcATag == $past(allocTag))));

  // R4: matching commit restores the ready state
  p_commit_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commitLive && !flush && !sameReg && !validVec[commitReg]
      && (tagVec[commitReg] == commitTag))
      |=> validVec[$past(commitReg)]);

  // R4: a stale commit leaves the younger mapping alone
  p_commit_stale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commitLive && !flush && !sameReg && !validVec[commitReg]
      && (tagVec[commitReg] != commitTag))
      |=> (!validVec[$past(commitReg)]
           && (tagVec[$past(commitReg)] == $past(tagVec[commitReg]))));

  // R5: committed data becomes visible
  p_commit_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commitLive ##1 (srcAReg == $past(commitReg)))
      |-> (srcAData == $past(commitData)));

  // R6: flush returns every register to ready
  p_flush_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (validVec == '1) && srcAValid && srcBValid);

  // R9: allocate overrides a same-cycle commit to the same register
  p_alloc_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sameReg && commitLive)
      |=> (!validVec[$past(allocReg)] && (tagVec[$past(allocReg)] == $past(allocTag))));

  if (ZERO_FIXED != 0) begin : g_zero
    // R8: register 0 is permanently ready and zero
    p_zero_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (srcAReg == '0) |-> (srcAValid && (srcATag == '0) && (srcAData == '0)));
  end

endmodule

bind reg_rename_table reg_rename_table_chk #(
  .NUM_REGS  (NUM_REGS),
  .TAG_W     (TAG_W),
  .DATA_W    (DATA_W),
  .ZERO_FIXED(ZERO_FIXED)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .srcAReg   (srcAReg),
  .srcAValid (srcAValid),
  .srcATag   (srcATag),
  .srcAData  (srcAData),
  .srcBValid (srcBValid),
  .allocEn   (allocEn),
  .allocReg  (allocReg),
  .allocTag  (allocTag),
  .commitEn  (commitEn),
  .commitReg (commitReg),
  .commitTag (commitTag),
  .commitData(commitData),
  .validVec  (validVec),
  .tagVec    (tagVec)
);

// File: tb/reg_rename_table_tb_top.sv
module reg_rename_table_tb_top;

  localparam int NUM_REGS = 32;
  localparam int TAG_W    = 6;
  localparam int DATA_W   = 32;
  localparam int REG_W    = $clog2(NUM_REGS);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              flush;
  logic [REG_W-1:0]  srcAReg, srcBReg;
  logic              srcAValid, srcBValid;
  logic [TAG_W-1:0]  srcATag, srcBTag;
  logic [DATA_W-1:0] srcAData, srcBData;
  logic              allocEn, commitEn;
  logic [REG_W-1:0]  allocReg, commitReg;
  logic [TAG_W-1:0]  allocTag, commitTag;
  logic [DATA_W-1:0] commitData;

  always #5 clk = ~clk;

  reg_rename_table dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .srcAReg(srcAReg), .srcBReg(srcBReg),
    .srcAValid(srcAValid), .srcATag(srcATag), .srcAData(srcAData),
    .srcBValid(srcBValid), .srcBTag(srcBTag), .srcBData(srcBData),
    .allocEn(allocEn), .allocReg(allocReg), .allocTag(allocTag),
    .commitEn(commitEn), .commitReg(commitReg), .commitTag(commitTag),
    .commitData(commitData)
  );

  // behavioural reference state
  bit              mValid [NUM_REGS];
  int unsigned     mTag   [NUM_REGS];
  int unsigned     mData  [NUM_REGS];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic checkPort(string req, string name, int unsigned r,
                           logic v, logic [TAG_W-1:0] t, logic [DATA_W-1:0] d);
    checks++;
    if (v !== mValid[r] || t !== TAG_W'(mTag[r]) || d !== DATA_W'(mData[r])) begin
      errors++;
      $display("FAIL %s port %s reg %0d: got v=%0b t=%0d d=%h exp v=%0b t=%0d d=%h",
               req, name, r, v, t, d, mValid[r], mTag[r], mData[r]);
    end
  endtask

  // one cycle: drive, compare against pre-edge model, then advance model
  task automatic step(string req, int unsigned a, int unsigned b,
                      bit fl, bit ae, int unsigned ar, int unsigned at,
                      bit ce, int unsigned cr, int unsigned ct, int unsigned cd);
    bit reval;
    @(negedge clk);
    srcAReg = REG_W'(a);  srcBReg = REG_W'(b);  flush = fl;
    allocEn = ae;  allocReg = REG_W'(ar);  allocTag = TAG_W'(at);
    commitEn = ce; commitReg = REG_W'(cr); commitTag = TAG_W'(ct);
    commitData = DATA_W'(cd);
    #1;
    checkPort(req, "A", a, srcAValid, srcATag, srcAData);
    checkPort(req, "B", b, srcBValid, srcBTag, srcBData);
    @(posedge clk);
    reval = ce && cr != 0 && !(ae && !fl && ar == cr) && !mValid[cr] && mTag[cr] == ct;
    if (ce && cr != 0) mData[cr] = cd;
    if (fl) begin
      for (int i = 0; i < NUM_REGS; i++) mValid[i] = 1;
    end else begin
      if (ae && ar != 0) begin mValid[ar] = 0; mTag[ar] = at; end
      if (reval) mValid[cr] = 1;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
    end
  end

  initial begin
    rst_n = 0; flush = 0; srcAReg = '0; srcBReg = '0;
    allocEn = 0; allocReg = '0; allocTag = '0;
    commitEn = 0; commitReg = '0; commitTag = '0; commitData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin mValid[i] = 1; mTag[i] = 0; mData[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset state on every register
    for (int i = 0; i < NUM_REGS; i += 2)
      step("R1", i, i + 1, 0, 0, 0, 0, 0, 0, 0, 0);

    // R2: allocate r5 tag 9, then read it
    step("R2", 5, 6, 0, 1, 5, 9, 0, 0, 0, 0);
    step("R2", 5, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3: younger writer of r5 takes over, r7 read on port B independently
    step("R3", 5, 7, 0, 1, 5, 12, 0, 0, 0, 0);
    step("R3", 7, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    // R4: stale commit (tag 9) keeps r5 pending; R5: data still written
    step("R4", 5, 0, 0, 0, 0, 0, 1, 5, 9, 32'h1111);
    step("R5", 5, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    // R4: matching commit (tag 12) makes r5 ready
    step("R4", 5, 0, 0, 0, 0, 0, 1, 5, 12, 32'h2222);
    step("R4", 5, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7: lookup sees state before same-cycle allocate and commit
    step("R7", 6, 5, 0, 1, 6, 3, 1, 5, 12, 32'h3333);
    step("R7", 6, 5, 0, 1, 6, 4, 1, 6, 3, 32'h4444);
    step("R7", 6, 6, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9: allocate and commit on the same register
    step("R9", 8, 0, 0, 1, 8, 20, 0, 0, 0, 0);
    step("R9", 8, 0, 0, 1, 8, 21, 1, 8, 20, 32'h5555);
    step("R9", 8, 8, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6: flush with a same-cycle allocate and commit
    step("R6", 8, 6, 1, 1, 9, 30, 1, 8, 99, 32'h6666);
    step("R6", 8, 9, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 6, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8: register 0 ignores allocate and commit
    step("R8", 0, 0, 0, 1, 0, 7, 1, 0, 7, 32'hdead);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R3: mixed traffic on a small register window
    for (int n = 0; n < 4000; n++) begin
      int unsigned cr, ct;
      cr = $urandom_range(0, 7);
      ct = ($urandom_range(0, 9) < 7) ? mTag[cr] : $urandom_range(0, 63);
      step("R3", $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 49) == 0,
           $urandom_range(0, 1) == 1, $urandom_range(0, 7), $urandom_range(0, 63),
           $urandom_range(0, 1) == 1, cr, ct, $urandom);
    end
    done = 1;
    summary();
  end

endmodule